// File: doc/BRIEF.md
# Branch Direction Predictor with Retire Update Queue

This block predicts whether a fetched conditional branch will be taken. Every fetch comes with a mode bit. In dynamic mode, the prediction is the upper bit of a 2-bit saturating counter. The counter sits in a table indexed by the branch's word address. In static mode, the prediction comes only from the sign of the branch displacement and a compiler hint bit, and the table is not read.

Branch outcomes come back from retirement. Up to two outcomes can arrive per cycle. The counter table has a single write port, so the second outcome of a pair is parked in a one-entry holding register and written on the following cycle. An outcome is lost only when a pair retires while that register is already occupied.

After reset, an internal sequencer writes every counter to weakly not taken, one entry per cycle. An output flag stays high while this runs.

Top module: `dir_predictor`

## Requirements
- R1: `init_busy` is high during reset. It falls at the 1026th rising clock edge after `rst_n` rises: two edges for the reset release and one edge per table entry.
- R2: Once initialisation ends, every counter holds weakly not taken (2'b01). A dynamic lookup of any untouched index predicts not taken.
- R3: Counters use 2'b00 for strongly not taken up to 2'b11 for strongly taken. A taken outcome increments the counter and a not-taken outcome decrements it, saturating at both ends. The prediction is bit 1 of the counter.
- R4: In static mode (`fetch_dyn`=0) with `fetch_hint`=0, a backward branch (`fetch_back`=1) predicts taken and a forward branch predicts not taken.
- R5: In static mode, `fetch_hint`=1 inverts the static prediction of R4.
- R6: `fetch_dyn`=1 selects the counter for `fetch_idx`, and `fetch_dyn`=0 selects the static rule. A dynamic lookup predicts not taken while `init_busy` is high.
- R7: Retiring outcomes are ignored while `init_busy` is high.
- R8: When both retire ports are valid and the holding register is empty, the port 0 outcome updates the table at the next edge and the port 1 outcome is held.
- R9: A held outcome is written at the next edge. If exactly one new outcome retires in that cycle, the new outcome takes the holding register.
- R10: When both ports are valid while the holding register is occupied, the held outcome is written, the port 0 outcome is held, and the port 1 outcome is discarded.
- R11: A dynamic lookup of the index being written in the same cycle returns the counter value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_idx | input | IDX_W | Word-address index bits of the fetched branch |
| fetch_dyn | input | 1 | 1 = dynamic (counter) prediction, 0 = static |
| fetch_back | input | 1 | Displacement sign: 1 = backward branch |
| fetch_hint | input | 1 | Static hint: 1 inverts the static convention |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| init_busy | output | 1 | Table initialisation in progress |
| ret0_vld | input | 1 | Older retiring branch valid |
| ret0_idx | input | IDX_W | Index of the older retiring branch |
| ret0_taken | input | 1 | Outcome of the older retiring branch |
| ret1_vld | input | 1 | Younger retiring branch valid |
| ret1_idx | input | IDX_W | Index of the younger retiring branch |
| ret1_taken | input | 1 | Outcome of the younger retiring branch |

## Verification
Random traffic confines the retire indices to a small pool, so that queued writes, same-index reads and counter saturation happen often. A bench model follows every counter and the holding register, and every cycle the design's prediction is compared with it. Directed sequences separate three cases that random traffic hides: a pair retiring into an empty holding register, a single branch replacing a drained entry, and a pair retiring into a full register. In each case, a later lookup shows which outcome was written, which was held and which was lost. Static lookups cover all four sign and hint combinations. A lookup and an update to the same index in the same cycle show that the old value is read.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    res = cur;
    if (taken && (cur != CTR_ST))       res = cur + 2'd1;
    else if (!taken && (cur != CTR_SNT)) res = cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/dp_init_seq.sv
module dp_init_seq #(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  output logic [IDX_W-1:0] wr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      busy_d = (cnt_q != LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy   = busy_q;
  assign wr_idx = cnt_q;

  assert_busy_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !busy_q);

endmodule

// File: rtl/dp_upd_queue.sv
module dp_upd_queue #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             r0_vld,
  input  logic [IDX_W-1:0] r0_idx,
  input  logic             r0_taken,
  input  logic             r1_vld,
  input  logic [IDX_W-1:0] r1_idx,
  input  logic             r1_taken,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_taken
);
  logic             q_vld_q, q_vld_d;
  logic [IDX_W-1:0] q_idx_q, q_idx_d;
  logic             q_tk_q,  q_tk_d;
  logic             load_q;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = r0_idx;
    wr_taken = r0_taken;
    q_vld_d  = q_vld_q;
    q_idx_d  = q_idx_q;
    q_tk_d   = q_tk_q;
    load_q   = 1'b0;
    if (!busy) begin
      if (q_vld_q) begin
        wr_en    = 1'b1;
        wr_idx   = q_idx_q;
        wr_taken = q_tk_q;
        load_q   = 1'b1;
        if (r0_vld) begin
          q_idx_d = r0_idx;
          q_tk_d  = r0_taken;
        end else if (r1_vld) begin
          q_idx_d = r1_idx;
          q_tk_d  = r1_taken;
        end else begin
          q_vld_d = 1'b0;
        end
      end else if (r0_vld) begin
        wr_en    = 1'b1;
        wr_idx   = r0_idx;
        wr_taken = r0_taken;
        if (r1_vld) begin
          load_q  = 1'b1;
          q_vld_d = 1'b1;
          q_idx_d = r1_idx;
          q_tk_d  = r1_taken;
        end
      end else if (r1_vld) begin
        wr_en    = 1'b1;
        wr_idx   = r1_idx;
        wr_taken = r1_taken;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld_q <= 1'b0;
    end else if (load_q) begin
      q_vld_q <= q_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_q) begin
      q_idx_q <= q_idx_d;
      q_tk_q  <= q_tk_d;
    end
  end

  assert_pair_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !q_vld_q && r0_vld && r1_vld) |=> q_vld_q);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && q_vld_q && !r0_vld && !r1_vld) |=> !q_vld_q);

  assert_full_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && q_vld_q && r0_vld && r1_vld) |=> (q_vld_q && q_idx_q == $past(r0_idx)));

endmodule

// File: rtl/dp_table.sv
module dp_table
  import dp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             init_en,
  input  logic [IDX_W-1:0] init_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  logic [1:0]       mem [ENTRIES];
  logic             we;
  logic [IDX_W-1:0] widx;
  logic [1:0]       wdat;

  always_comb begin
    we   = init_en | upd_en;
    widx = init_en ? init_idx : upd_idx;
    wdat = init_en ? CTR_WNT : ctr_step(mem[upd_idx], upd_taken);
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  assign rd_ctr = mem[rd_idx];

  assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !init_en && upd_taken && mem[upd_idx] == CTR_ST)
      |=> mem[$past(upd_idx)] == CTR_ST);

  assert_sat_bot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !init_en && !upd_taken && mem[upd_idx] == CTR_SNT)
      |=> mem[$past(upd_idx)] == CTR_SNT);

endmodule

// File: rtl/dp_static.sv
module dp_static (
  input  logic back,
  input  logic hint,
  output logic taken
);
  always_comb taken = back ^ hint;
endmodule

// File: rtl/dir_predictor.sv
module dir_predictor #(
  parameter int ENTRIES = 1024,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] fetch_idx,
  input  logic             fetch_dyn,
  input  logic             fetch_back,
  input  logic             fetch_hint,
  output logic             pred_taken,
  output logic             init_busy,
  input  logic             ret0_vld,
  input  logic [IDX_W-1:0] ret0_idx,
  input  logic             ret0_taken,
  input  logic             ret1_vld,
  input  logic [IDX_W-1:0] ret1_idx,
  input  logic             ret1_taken
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             busy;
  logic [IDX_W-1:0] init_idx;
  logic             wr_en, wr_taken;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       ctr;
  logic             stat_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dp_init_seq #(.ENTRIES(ENTRIES)) u_init (
    .clk(clk), .rst_n(rst_int_n), .busy(busy), .wr_idx(init_idx)
  );

  dp_upd_queue #(.IDX_W(IDX_W)) u_queue (
    .clk(clk), .rst_n(rst_int_n), .busy(busy),
    .r0_vld(ret0_vld), .r0_idx(ret0_idx), .r0_taken(ret0_taken),
    .r1_vld(ret1_vld), .r1_idx(ret1_idx), .r1_taken(ret1_taken),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_taken(wr_taken)
  );

  dp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(fetch_idx), .rd_ctr(ctr),
    .init_en(busy), .init_idx(init_idx),
    .upd_en(wr_en), .upd_idx(wr_idx), .upd_taken(wr_taken)
  );

  dp_static u_static (.back(fetch_back), .hint(fetch_hint), .taken(stat_taken));

  always_comb begin
    if (fetch_dyn) pred_taken = busy ? 1'b0 : ctr[1];
    else           pred_taken = stat_taken;
  end

  assign init_busy = busy;

  assert_no_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  assert_busy_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fetch_dyn) |-> !pred_taken);

endmodule

// File: tb/sim_dir_predictor.sv
module sim_dir_predictor;
  localparam int ENTRIES = 1024;
  localparam int IDX_W   = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [IDX_W-1:0] fetch_idx;
  logic             fetch_dyn, fetch_back, fetch_hint;
  logic             pred_taken, init_busy;
  logic             ret0_vld, ret0_taken, ret1_vld, ret1_taken;
  logic [IDX_W-1:0] ret0_idx, ret1_idx;

  int checks = 0;
  int errors = 0;

  logic [1:0]       mdl [ENTRIES];
  logic             mq_vld;
  logic [IDX_W-1:0] mq_idx;
  logic             mq_tk;

  always #10 clk = ~clk;

  dir_predictor #(.ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_idx(fetch_idx), .fetch_dyn(fetch_dyn), .fetch_back(fetch_back),
    .fetch_hint(fetch_hint), .pred_taken(pred_taken), .init_busy(init_busy),
    .ret0_vld(ret0_vld), .ret0_idx(ret0_idx), .ret0_taken(ret0_taken),
    .ret1_vld(ret1_vld), .ret1_idx(ret1_idx), .ret1_taken(ret1_taken)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t)  return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic model_write(input logic [IDX_W-1:0] i, input logic t);
    mdl[i] = sat(mdl[i], t);
  endtask

  task automatic look(input string req, input logic [IDX_W-1:0] i, input logic dyn,
                      input logic bk, input logic hn, input logic exp);
    fetch_idx = i; fetch_dyn = dyn; fetch_back = bk; fetch_hint = hn;
    #1;
    check(req, pred_taken, exp);
  endtask

  // one clock: retire inputs driven now, model updated with the same rules as the requirements
  task automatic cyc(input logic v0, input logic [IDX_W-1:0] i0, input logic t0,
                     input logic v1, input logic [IDX_W-1:0] i1, input logic t1);
    logic bsy;
    ret0_vld = v0; ret0_idx = i0; ret0_taken = t0;
    ret1_vld = v1; ret1_idx = i1; ret1_taken = t1;
    bsy = init_busy;
    @(posedge clk);
    if (!bsy) begin
      if (mq_vld) begin
        model_write(mq_idx, mq_tk);
        if (v0)      begin mq_idx = i0; mq_tk = t0; end
        else if (v1) begin mq_idx = i1; mq_tk = t1; end
        else mq_vld = 1'b0;
      end else if (v0) begin
        model_write(i0, t0);
        if (v1) begin mq_vld = 1'b1; mq_idx = i1; mq_tk = t1; end
      end else if (v1) begin
        model_write(i1, t1);
      end
    end
    @(negedge clk);
    ret0_vld = 1'b0; ret1_vld = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int seed;
    seed = $urandom(32'd7171);
    rst_n = 1'b0;
    fetch_idx = '0; fetch_dyn = 1'b1; fetch_back = 1'b0; fetch_hint = 1'b0;
    ret0_vld = 1'b0; ret0_idx = '0; ret0_taken = 1'b0;
    ret1_vld = 1'b0; ret1_idx = '0; ret1_taken = 1'b0;
    mq_vld = 1'b0; mq_idx = '0; mq_tk = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy in reset", init_busy, 1'b1);
    check("R6 dyn lookup while busy", pred_taken, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: retirements during init must leave no trace
    cyc(1'b1, 10'd7, 1'b1, 1'b1, 10'd8, 1'b1);
    cyc(1'b1, 10'd7, 1'b1, 1'b0, 10'd0, 1'b0);
    cnt = 2;
    look("R4 static during busy", 10'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    while (init_busy && cnt < 3000) begin
      @(posedge clk); #1; cnt++;
    end
    check("R1 busy length 1026", (cnt == 1026), 1'b1);
    @(negedge clk);
    for (int k = 0; k < ENTRIES; k++) mdl[k] = 2'b01;
    mq_vld = 1'b0;

    look("R7 ignored during busy idx7", 10'd7, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R7 ignored during busy idx8", 10'd8, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R2 init weakly not taken", 10'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R2 init last entry", 10'd1023, 1'b1, 1'b0, 1'b0, 1'b0);

    // R3 counter walk at index 5
    cyc(1'b1, 10'd5, 1'b1, 1'b0, 10'd0, 1'b0);
    look("R3 01->10 taken", 10'd5, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 10'd5, 1'b1, 1'b0, 10'd0, 1'b0);
    cyc(1'b1, 10'd5, 1'b1, 1'b0, 10'd0, 1'b0);
    cyc(1'b1, 10'd5, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R3 saturate 11 then 10", 10'd5, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 10'd5, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R3 01 not taken", 10'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 10'd5, 1'b0, 1'b0, 10'd0, 1'b0);
    cyc(1'b1, 10'd5, 1'b0, 1'b0, 10'd0, 1'b0);
    cyc(1'b1, 10'd5, 1'b1, 1'b0, 10'd0, 1'b0);
    look("R3 saturate 00 then 01", 10'd5, 1'b1, 1'b0, 1'b0, 1'b0);

    // R4/R5 static
    look("R4 backward taken",   10'd5, 1'b0, 1'b1, 1'b0, 1'b1);
    look("R4 forward not taken", 10'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    look("R5 hint forward",     10'd5, 1'b0, 1'b0, 1'b1, 1'b1);
    look("R5 hint backward",    10'd5, 1'b0, 1'b1, 1'b1, 1'b0);

    // R8/R9 pair into empty queue
    cyc(1'b1, 10'd20, 1'b1, 1'b1, 10'd21, 1'b1);
    look("R8 port0 written", 10'd20, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R8 port1 held",    10'd21, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R6 static overrides counter", 10'd20, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 10'd0, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R9 held written next", 10'd21, 1'b1, 1'b0, 1'b0, 1'b1);

    // R9 single retire takes slot
    cyc(1'b1, 10'd30, 1'b1, 1'b1, 10'd31, 1'b1);
    cyc(1'b0, 10'd0, 1'b0, 1'b1, 10'd32, 1'b1);
    look("R9 drained entry written", 10'd31, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R9 single now held",       10'd32, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 10'd0, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R9 single written later",  10'd32, 1'b1, 1'b0, 1'b0, 1'b1);

    // R10 pair into full queue drops port 1
    cyc(1'b1, 10'd40, 1'b1, 1'b1, 10'd41, 1'b1);
    cyc(1'b1, 10'd42, 1'b1, 1'b1, 10'd43, 1'b1);
    cyc(1'b0, 10'd0, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R10 held written",  10'd41, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R10 port0 held then written", 10'd42, 1'b1, 1'b0, 1'b0, 1'b1);
    look("R10 port1 dropped", 10'd43, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 10'd0, 1'b0, 1'b0, 10'd0, 1'b0);
    look("R10 dropped stays", 10'd43, 1'b1, 1'b0, 1'b0, 1'b0);

    // R11 read before write
    fetch_idx = 10'd50; fetch_dyn = 1'b1; fetch_back = 1'b0; fetch_hint = 1'b0;
    ret0_vld = 1'b1; ret0_idx = 10'd50; ret0_taken = 1'b1;
    #1;
    check("R11 same-cycle old value", pred_taken, 1'b0);
    cyc(1'b1, 10'd50, 1'b1, 1'b0, 10'd0, 1'b0);
    look("R11 new value after edge", 10'd50, 1'b1, 1'b0, 1'b0, 1'b1);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [IDX_W-1:0] fi, i0, i1;
      logic d, b, h, v0, v1, t0, t1, e;
      fi = IDX_W'($urandom_range(60, 67));
      i0 = IDX_W'($urandom_range(60, 67));
      i1 = IDX_W'($urandom_range(60, 67));
      d = ($urandom_range(0, 3) != 0);
      b = 1'($urandom); h = 1'($urandom);
      v0 = 1'($urandom); v1 = 1'($urandom);
      t0 = ($urandom_range(0, 2) != 0); t1 = ($urandom_range(0, 2) == 0);
      ret0_vld = v0; ret0_idx = i0; ret0_taken = t0;
      ret1_vld = v1; ret1_idx = i1; ret1_taken = t1;
      e = d ? mdl[fi][1] : (b ^ h);
      look("R6 random vs model", fi, d, b, h, e);
      cyc(v0, i0, t0, v1, i1, t1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule